// File: doc/BRIEF.md
# Load-Balancing Destination Selection Agent

This block sits beside one node of a multi-node fabric and decides which of several identical downstream processing elements should receive that node's next data. A small table holds, for each candidate, the network address to send to and its distance from the host in hops. Candidates announce how available they are through short report messages; the agent keeps the latest availability value of each one.

Once every programmable interval the agent walks the table one candidate per cycle. It scores each candidate as a signed difference of two shifted terms: availability shifted left by one weight, minus hop distance shifted left by another. It keeps the best score and publishes the winning index and address. A candidate that has not reported for four intervals is treated as failed and skipped until it reports again. If every candidate has failed, a no-destination flag is raised instead of an address.

Top module: `load_balance_agent`

## Requirements
- R1: A table write (`cfg_we`) stores an address and a hop distance for candidate `cfg_idx`, and later selections use the stored values.
- R2: A report (`rpt_valid`) stores `rpt_avail` as the availability of candidate `rpt_idx` and restarts that candidate's silence count.
- R3: Each healthy candidate scores (avail << load_sh) − (hops << hop_sh), compared as a signed value, and the highest score wins. The shift amounts and the interval are loaded together on `par_we`.
- R4: When two or more healthy candidates share the best score, the lowest index wins.
- R5: A selection starts once every `par_period` cycles and scans NUM cycles. It ends with a one-cycle `sel_done` pulse, and the outputs change only with that pulse, so successive pulses are `par_period` cycles apart when the period exceeds NUM.
- R6: A candidate with no report for 4·`par_period` cycles is left out of every selection.
- R7: A left-out candidate takes part again in the first selection that scans it after a new report.
- R8: When no candidate is healthy, a selection sets `no_dest` = 1 with `dst_idx` = 0 and `dst_addr` = 0; otherwise `no_dest` = 0.
- R9: After reset `no_dest` = 1, `sel_done` = 0 and both destination outputs are 0. All table entries and availabilities are 0, every candidate counts as healthy, both shifts are 0 and the interval is DEF_T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IW | Candidate index written |
| cfg_addr | input | AW | Address of that candidate |
| cfg_hops | input | MW | Hop distance of that candidate |
| par_we | input | 1 | Load shifts and interval |
| par_load_sh | input | SW | Left shift applied to availability |
| par_hop_sh | input | SW | Left shift applied to hop distance |
| par_period | input | TW | Selection interval in cycles |
| rpt_valid | input | 1 | Report strobe |
| rpt_idx | input | IW | Reporting candidate |
| rpt_avail | input | MW | Availability carried by the report |
| sel_done | output | 1 | One-cycle pulse at the end of a selection |
| no_dest | output | 1 | No healthy candidate |
| dst_idx | output | IW | Winning candidate index |
| dst_addr | output | AW | Winning candidate address |

## Verification
The bench sweeps the shift pair over many combinations against arithmetic scores. These sweeps catch a design that compares unsigned and picks a negative score as the largest, or that swaps the two weights. Equal scores across all candidates catch a design whose comparison lets a later index overwrite an earlier one. A silenced favourite must drop out and come back after one report, and a fully silent table must raise `no_dest`. A design that never times candidates out, or never clears the timeout, would keep naming the dead candidate or never name it again. Measured gaps between completion pulses catch an interval counter that is off by one.

// File: rtl/load_balance_agent.sv
module load_balance_agent #(
  parameter int NUM   = 8,
  parameter int AW    = 6,
  parameter int MW    = 8,
  parameter int SW    = 3,
  parameter int FW    = 20,
  parameter int TW    = 12,
  parameter int DEF_T = 64,
  localparam int IW   = $clog2(NUM)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic [MW-1:0] cfg_hops,
  input  logic          par_we,
  input  logic [SW-1:0] par_load_sh,
  input  logic [SW-1:0] par_hop_sh,
  input  logic [TW-1:0] par_period,
  input  logic          rpt_valid,
  input  logic [IW-1:0] rpt_idx,
  input  logic [MW-1:0] rpt_avail,
  output logic          sel_done,
  output logic          no_dest,
  output logic [IW-1:0] dst_idx,
  output logic [AW-1:0] dst_addr
);

  logic [AW-1:0]   addr_q  [NUM];
  logic [MW-1:0]   hops_q  [NUM];
  logic [MW-1:0]   avail_q [NUM];
  logic [TW+1:0]   age_q   [NUM];
  logic [NUM-1:0]  live;

  logic [SW-1:0]   lsh_q, ksh_q;
  logic [TW-1:0]   per_q, cnt_q;
  logic [TW+1:0]   lim;
  logic            tick;

  logic            busy_q, acc_found_q;
  logic [IW-1:0]   sidx_q, acc_idx_q, win_idx;
  logic signed [FW-1:0] acc_fit_q, fit;
  logic [FW-1:0]   s_term, h_term;
  logic            better, found, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) begin
        addr_q[i] <= '0;
        hops_q[i] <= '0;
      end
    end else if (cfg_we) begin
      addr_q[cfg_idx] <= cfg_addr;
      hops_q[cfg_idx] <= cfg_hops;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsh_q <= '0;
      ksh_q <= '0;
      per_q <= TW'(DEF_T);
    end else if (par_we) begin
      lsh_q <= par_load_sh;
      ksh_q <= par_hop_sh;
      per_q <= par_period;
    end
  end

  assign lim = {per_q, 2'b00};

  for (genvar g = 0; g < NUM; g++) begin : g_cand
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        avail_q[g] <= '0;
        age_q[g]   <= '0;
      end else if (rpt_valid && rpt_idx == IW'(g)) begin
        avail_q[g] <= rpt_avail;
        age_q[g]   <= '0;
      end else if (age_q[g] < lim) begin
        age_q[g]   <= age_q[g] + 1'b1;
      end
    end
    assign live[g] = age_q[g] < lim;
  end

  assign tick = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, per_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign s_term  = FW'(avail_q[sidx_q]) << lsh_q;
  assign h_term  = FW'(hops_q[sidx_q]) << ksh_q;
  assign fit     = signed'(s_term - h_term);
  assign better  = live[sidx_q] && (!acc_found_q || fit > acc_fit_q);
  assign win_idx = better ? sidx_q : acc_idx_q;
  assign found   = acc_found_q || better;
  assign last    = sidx_q == IW'(NUM-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      sidx_q      <= '0;
      acc_found_q <= 1'b0;
      acc_idx_q   <= '0;
      acc_fit_q   <= '0;
      sel_done    <= 1'b0;
      no_dest     <= 1'b1;
      dst_idx     <= '0;
      dst_addr    <= '0;
    end else begin
      sel_done <= 1'b0;
      if (!busy_q) begin
        if (tick) begin
          busy_q      <= 1'b1;
          sidx_q      <= '0;
          acc_found_q <= 1'b0;
        end
      end else begin
        if (better) begin
          acc_found_q <= 1'b1;
          acc_idx_q   <= sidx_q;
          acc_fit_q   <= fit;
        end
        if (last) begin
          busy_q   <= 1'b0;
          sel_done <= 1'b1;
          no_dest  <= !found;
          dst_idx  <= found ? win_idx : '0;
          dst_addr <= found ? addr_q[win_idx] : '0;
        end else begin
          sidx_q <= sidx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/load_balance_agent_chk.sv
module load_balance_agent_chk #(
  parameter int NUM = 8,
  parameter int IW  = 3,
  parameter int AW  = 6
)(
  input logic          clk,
  input logic          rst_n,
  input logic          sel_done,
  input logic          no_dest,
  input logic [IW-1:0] dst_idx,
  input logic [AW-1:0] dst_addr
);

  logic [IW:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap <= (IW+1)'(NUM);
    else if (sel_done)            gap <= '0;
    else if (gap < (IW+1)'(NUM))  gap <= gap + 1'b1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> !sel_done);

  // R5
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> gap >= (IW+1)'(NUM));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_done |-> ($stable(dst_idx) && $stable(dst_addr) && $stable(no_dest)));

  // R8
  no_dest_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_dest |-> (dst_idx == '0 && dst_addr == '0));

endmodule

bind load_balance_agent load_balance_agent_chk #(.NUM(NUM), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_done(sel_done), .no_dest(no_dest),
  .dst_idx(dst_idx), .dst_addr(dst_addr)
);

// File: tb/tb_load_balance_agent.sv
`timescale 1ns/1ps
module tb_load_balance_agent;

  localparam int NUM = 8, AW = 6, MW = 8, SW = 3, TW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, par_we = 0, rpt_valid = 0;
  logic [2:0] cfg_idx = '0, rpt_idx = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [MW-1:0] cfg_hops = '0, rpt_avail = '0;
  logic [SW-1:0] par_load_sh = '0, par_hop_sh = '0;
  logic [TW-1:0] par_period = '0;
  logic sel_done, no_dest;
  logic [2:0] dst_idx;
  logic [AW-1:0] dst_addr;

  int errors = 0, checks = 0;
  int ld[NUM], hp[NUM], ad[NUM];
  int cur_l = 0, cur_k = 0;

  always #4 clk = ~clk;

  load_balance_agent dut (.*);

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tck();
    @(posedge clk); #1;
  endtask

  task automatic wr_cfg(int i, int a, int h);
    cfg_we = 1; cfg_idx = 3'(i); cfg_addr = AW'(a); cfg_hops = MW'(h);
    tck(); cfg_we = 0;
    ad[i] = a; hp[i] = h;
  endtask

  task automatic set_par(int l, int k, int t);
    par_we = 1; par_load_sh = SW'(l); par_hop_sh = SW'(k); par_period = TW'(t);
    tck(); par_we = 0;
    cur_l = l; cur_k = k;
  endtask

  task automatic report(int i, int s);
    rpt_valid = 1; rpt_idx = 3'(i); rpt_avail = MW'(s);
    tck(); rpt_valid = 0;
    ld[i] = s;
  endtask

  task automatic send_all(logic [NUM-1:0] skip);
    for (int i = 0; i < NUM; i++) if (!skip[i]) report(i, ld[i]);
  endtask

  task automatic wait_done();
    int w = 0;
    do begin tck(); w++; end while (!sel_done && w < 2000);
    if (w >= 2000) chk("R5 timeout", 0, 1);
  endtask

  function automatic int best(logic [NUM-1:0] alive);
    int b = -1, bf = 0;
    for (int i = 0; i < NUM; i++) begin
      int f = (ld[i] << cur_l) - (hp[i] << cur_k);
      if (alive[i] && (b < 0 || f > bf)) begin b = i; bf = f; end
    end
    return b;
  endfunction

  task automatic expect_sel(string req, logic [NUM-1:0] alive);
    int b = best(alive);
    wait_done(); wait_done();
    if (b < 0) begin
      chk({req, " no_dest"}, int'(no_dest), 1);
      chk({req, " idx"}, int'(dst_idx), 0);
      chk({req, " addr"}, int'(dst_addr), 0);
    end else begin
      chk({req, " no_dest"}, int'(no_dest), 0);
      chk({req, " idx"}, int'(dst_idx), b);
      chk({req, " addr"}, int'(dst_addr), ad[b]);
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < NUM; i++) begin ld[i] = 0; hp[i] = 0; ad[i] = 0; end
    repeat (3) tck();
    chk("R9 reset no_dest", int'(no_dest), 1);
    chk("R9 reset done", int'(sel_done), 0);
    chk("R9 reset idx", int'(dst_idx), 0);
    chk("R9 reset addr", int'(dst_addr), 0);
    rst_n = 1;
    tck();
    wait_done();
    chk("R9 first pick idx", int'(dst_idx), 0);
    chk("R9 first pick no_dest", int'(no_dest), 0);
    n = 0;
    do begin tck(); n++; end while (!sel_done && n < 500);
    chk("R9 default interval", n, 64);

    for (int i = 0; i < NUM; i++) wr_cfg(i, (i*7+5) % 64, (i*5+2) % 9 + 1);
    set_par(0, 0, 20);
    wait_done(); wait_done();
    n = 0;
    do begin tck(); n++; end while (!sel_done && n < 500);
    chk("R5 interval 20", n, 20);
    set_par(0, 0, 30);
    wait_done(); wait_done();
    n = 0;
    do begin tck(); n++; end while (!sel_done && n < 500);
    chk("R5 interval 30", n, 30);

    for (int i = 0; i < NUM; i++) ld[i] = (i*53 + 29) % 256;
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 4; k++) begin
        set_par(l, k, 20);
        send_all('0);
        expect_sel("R3 R1 R2 sweep", '1);
      end

    for (int i = 0; i < NUM; i++) ld[i] = (i*29 + 101) % 256;
    set_par(7, 0, 20); send_all('0); expect_sel("R3 max load shift", '1);
    set_par(0, 7, 20); send_all('0); expect_sel("R3 max hop shift", '1);

    for (int i = 0; i < NUM; i++) ld[i] = 0;
    set_par(0, 2, 20); send_all('0); expect_sel("R3 negative scores", '1);

    for (int i = 0; i < NUM; i++) ld[i] = hp[i] + 10;
    set_par(0, 0, 20); send_all('0); expect_sel("R4 all tied", '1);
    chk("R4 tie lowest", int'(dst_idx), 0);
    ld[2] = hp[2] + 40; ld[6] = hp[6] + 40;
    send_all('0); expect_sel("R4 pair tied", '1);
    chk("R4 tie 2 over 6", int'(dst_idx), 2);

    for (int i = 0; i < NUM; i++) ld[i] = 120;
    set_par(0, 0, 20); send_all('0); expect_sel("R1 before rewrite", '1);
    wr_cfg(best('1), 60, 250);
    send_all('0); expect_sel("R1 hops rewrite", '1);

    for (int i = 0; i < NUM; i++) ld[i] = 50;
    ld[3] = 255;
    set_par(1, 0, 20); send_all('0); expect_sel("R6 favourite alive", '1);
    chk("R6 favourite idx", int'(dst_idx), 3);
    for (int r = 0; r < 12; r++) begin send_all(8'h08); tck(); end
    expect_sel("R6 silent excluded", 8'hF7);
    report(3, 255); send_all('0);
    expect_sel("R7 reinstated", '1);
    chk("R7 back idx", int'(dst_idx), 3);

    repeat (100) tck();
    expect_sel("R8 all silent", '0);
    report(5, 10);
    expect_sel("R7 single back", 8'h20);
    chk("R8 cleared", int'(no_dest), 0);

    finish_run();
  end

endmodule